// File: doc/BRIEF.md
# Ethernet MAC Operating-Mode Control Register

This block holds the operating-mode settings of an Ethernet MAC and drives the run/stop state of its receive engine. The host writes one 16-bit control word. Each field in that word is protected by its own write condition. A field that affects transmit timing changes only while the transmit engine reports that it is stopped. A field that affects address filtering changes only while the receive engine is stopped. The loopback mode selector needs both engines to be stopped. If a write breaks a field's condition, that field keeps its old value, and the other fields in the same word still take their new values.

The receive engine has three states: stopped, running and suspended. Setting the receive-enable bit starts the engine. Clearing the bit stops it, but never in the middle of a frame: a frame already in progress finishes first. While running, the engine suspends when it has no receive buffer and no frame in progress, and it resumes when a buffer becomes available. The control word reads back the stored fields and the 2-bit receive state. Reserved bits read as zero. Control frames (pause, wake-up) received in the stopped state belong to the datapath and are outside this block.

Top module: `mac_mode_ctl`

## Requirements
- R1: After synchronous reset, every field is 0, the receive state is 00 (stopped), and rd_data is 0x0000.
- R2: The receive-enable bit (bit 0) takes the written value on every write, whatever the state of the engines.
- R3: Pass-bad (bit 1), promiscuous (bit 2) and multicast-all (bit 3) take the written value only when the receive state is stopped at the write edge. Otherwise they keep their old value.
- R4: Force-collision (bit 6) and stop-backoff (bit 7) take the written value only when tx_stopped is 1 at the write edge. Otherwise they keep their old value.
- R5: The operating mode (bits 5:4) takes the written value only when tx_stopped is 1 and the receive state is stopped at the write edge.
- R6: In a write where some fields are allowed and some are blocked, the allowed fields update and the blocked fields keep their values.
- R7: mac_loopback is 1 exactly when the stored operating mode is 01. Codes 10 and 11 are stored and read back, but they select normal operation (mac_loopback 0).
- R8: rd_data bits 15:10 always read 0, whatever is written to them.
- R9: rd_data bits 9:8 and the rx_state output show the receive state: 00 stopped, 01 running, 10 suspended. Writes to bits 9:8 are ignored.
- R10: If the receive-enable bit is 1 while the state is stopped, the state becomes running on the next edge. A write of 1 at edge N shows running after edge N+1.
- R11: If the receive-enable bit is 0 while running with no frame in progress, the state becomes stopped on the next edge. If a frame is in progress, the state stays running and becomes stopped on the edge where rx_frm_end is seen.
- R12: While running with no frame in progress, no rx_frm_start and rx_buf_empty at 1, the state goes to suspended on the next edge. From suspended, rx_buf_empty at 0 returns the state to running, and a 0 receive-enable bit sends it to stopped.
- R13: rx_frm_start opens a frame in progress only in the running state. A start strobe seen while stopped does not later delay a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word write data |
| rd_data | output | 16 | Control word read data, including the receive state |
| tx_stopped | input | 1 | Transmit engine reports that it is stopped |
| rx_frm_start | input | 1 | Receive frame start strobe |
| rx_frm_end | input | 1 | Receive frame end strobe |
| rx_buf_empty | input | 1 | No receive buffer is available |
| force_coll | output | 1 | Force a collision on transmit (test use) |
| op_mode | output | 2 | Stored operating-mode code |
| mac_loopback | output | 1 | MAC loopback selected |
| mcast_all | output | 1 | Accept all multicast frames |
| promisc | output | 1 | Accept any good frame |
| stop_backoff | output | 1 | Hold the backoff counter while carrier is present |
| pass_bad | output | 1 | Pass frames with errors that pass the address filter |
| rx_start | output | 1 | Stored receive-enable bit |
| rx_state | output | 2 | Receive state code |

## Verification
Two things can land on the same clock edge. The first is a guarded write arriving while the receive engine is leaving or entering the stopped state. The second is a pending stop request arriving in the same cycle as the end-of-frame strobe. The bench creates the first case by writing the receive-enable bit and a guarded field in sequence, and sweeping every pattern against each tx/rx stopped combination. It checks that the guard follows the registered state at the write edge and not the state being requested. It creates the second case by clearing the enable bit during a frame and checking that the state changes to stopped exactly on the edge that carries rx_frm_end, and not earlier.

// File: rtl/mac_mode_pkg.sv
package mac_mode_pkg;

    localparam int REG_W      = 16;
    localparam int FQ_W       = 2;
    localparam int NUM_FIELDS = 7;
    localparam int STATE_LSB  = 8;

    typedef enum logic [1:0] {
        G_NONE = 2'd0,
        G_TX   = 2'd1,
        G_RX   = 2'd2,
        G_BOTH = 2'd3
    } guard_e;

    typedef enum logic [1:0] {
        RX_STOPPED   = 2'b00,
        RX_RUNNING   = 2'b01,
        RX_SUSPENDED = 2'b10
    } rx_state_e;

    typedef struct packed {
        logic [4:0] lsb;
        logic [1:0] width;
        guard_e     guard;
    } fdesc_t;

    localparam int F_RX_START = 0;
    localparam int F_PASS_BAD = 1;
    localparam int F_PROMISC  = 2;
    localparam int F_MCAST    = 3;
    localparam int F_OP_MODE  = 4;
    localparam int F_FCOLL    = 5;
    localparam int F_STOP_BO  = 6;

    localparam fdesc_t FIELDS [NUM_FIELDS] = '{
        '{lsb: 5'd0, width: 2'd1, guard: G_NONE},
        '{lsb: 5'd1, width: 2'd1, guard: G_RX},
        '{lsb: 5'd2, width: 2'd1, guard: G_RX},
        '{lsb: 5'd3, width: 2'd1, guard: G_RX},
        '{lsb: 5'd4, width: 2'd2, guard: G_BOTH},
        '{lsb: 5'd6, width: 2'd1, guard: G_TX},
        '{lsb: 5'd7, width: 2'd1, guard: G_TX}
    };

    function automatic logic guard_ok(guard_e g, logic tx_idle, logic rx_idle);
        case (g)
            G_TX:    return tx_idle;
            G_RX:    return rx_idle;
            G_BOTH:  return tx_idle & rx_idle;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/mode_field.sv
module mode_field
    import mac_mode_pkg::*;
#(
    parameter int     WIDTH = 1,
    parameter guard_e GUARD = G_NONE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_val,
    input  logic             tx_idle,
    input  logic             rx_idle,
    output logic [WIDTH-1:0] q
);

    logic allow;
    assign allow = guard_ok(GUARD, tx_idle, rx_idle);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en && allow) begin
            q <= wr_val;
        end
    end

    // R6: a blocked write leaves the field untouched
    p_blocked_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !guard_ok(GUARD, tx_idle, rx_idle)) |=> (q == $past(q)));

    // R2: an allowed write lands on the next edge
    p_allowed_take_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && guard_ok(GUARD, tx_idle, rx_idle)) |=> (q == $past(wr_val)));

    // no write, no change
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/rx_run_fsm.sv
module rx_run_fsm
    import mac_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run_bit,
    input  logic      frm_start,
    input  logic      frm_end,
    input  logic      buf_empty,
    output rx_state_e state,
    output logic      in_frame
);

    rx_state_e st_n;
    logic      in_n;

    always_comb begin
        st_n = state;
        in_n = in_frame;
        case (state)
            RX_STOPPED: begin
                in_n = 1'b0;
                if (run_bit) st_n = RX_RUNNING;
            end
            RX_RUNNING: begin
                if (in_frame && frm_end)
                    in_n = 1'b0;
                else if (!in_frame && frm_start)
                    in_n = 1'b1;
                if (!run_bit) begin
                    if (!in_frame || frm_end) begin
                        st_n = RX_STOPPED;
                        in_n = 1'b0;
                    end
                end else if (!in_frame && !frm_start && buf_empty) begin
                    st_n = RX_SUSPENDED;
                end
            end
            RX_SUSPENDED: begin
                in_n = 1'b0;
                if (!run_bit)
                    st_n = RX_STOPPED;
                else if (!buf_empty)
                    st_n = RX_RUNNING;
            end
            default: begin
                st_n = RX_STOPPED;
                in_n = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_STOPPED;
            in_frame <= 1'b0;
        end else begin
            state    <= st_n;
            in_frame <= in_n;
        end
    end

    p_start_runs_r10: assert property (@(posedge clk) disable iff (rst)
        (state == RX_STOPPED && run_bit) |=> (state == RX_RUNNING));

    p_stop_waits_frame_r11: assert property (@(posedge clk) disable iff (rst)
        (state == RX_RUNNING && in_frame && !frm_end) |=> (state != RX_STOPPED));

    p_suspend_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (state == RX_SUSPENDED) |-> !in_frame);

    p_legal_code_r9: assert property (@(posedge clk) disable iff (rst)
        state != 2'b11);

    p_no_frame_stopped_r13: assert property (@(posedge clk) disable iff (rst)
        (state == RX_STOPPED) |=> !in_frame);

endmodule

// File: rtl/mode_rdmux.sv
module mode_rdmux
    import mac_mode_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][FQ_W-1:0] fq,
    input  rx_state_e                       state,
    output logic [REG_W-1:0]                word
);

    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            for (int b = 0; b < FQ_W; b++) begin
                if (b < int'(FIELDS[i].width))
                    word[int'(FIELDS[i].lsb) + b] = fq[i][b];
            end
        end
        word[STATE_LSB +: 2] = state;
    end

endmodule

// File: rtl/mac_mode_ctl.sv
module mac_mode_ctl
    import mac_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             tx_stopped,
    input  logic             rx_frm_start,
    input  logic             rx_frm_end,
    input  logic             rx_buf_empty,
    output logic             force_coll,
    output logic [1:0]       op_mode,
    output logic             mac_loopback,
    output logic             mcast_all,
    output logic             promisc,
    output logic             stop_backoff,
    output logic             pass_bad,
    output logic             rx_start,
    output logic [1:0]       rx_state
);

    logic [NUM_FIELDS-1:0][FQ_W-1:0] fq;
    rx_state_e                       st;
    logic                            in_frame;
    logic                            rx_idle;

    assign rx_idle = (st == RX_STOPPED);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam int W   = int'(FIELDS[i].width);
        localparam int LSB = int'(FIELDS[i].lsb);
        logic [W-1:0] q;

        mode_field #(
            .WIDTH (W),
            .GUARD (FIELDS[i].guard)
        ) u_field (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_val  (wr_data[LSB +: W]),
            .tx_idle (tx_stopped),
            .rx_idle (rx_idle),
            .q       (q)
        );

        assign fq[i] = FQ_W'(q);
    end

    rx_run_fsm u_rx (
        .clk       (clk),
        .rst       (rst),
        .run_bit   (fq[F_RX_START][0]),
        .frm_start (rx_frm_start),
        .frm_end   (rx_frm_end),
        .buf_empty (rx_buf_empty),
        .state     (st),
        .in_frame  (in_frame)
    );

    mode_rdmux u_rd (
        .fq    (fq),
        .state (st),
        .word  (rd_data)
    );

    assign rx_start     = fq[F_RX_START][0];
    assign pass_bad     = fq[F_PASS_BAD][0];
    assign promisc      = fq[F_PROMISC][0];
    assign mcast_all    = fq[F_MCAST][0];
    assign op_mode      = fq[F_OP_MODE];
    assign force_coll   = fq[F_FCOLL][0];
    assign stop_backoff = fq[F_STOP_BO][0];
    assign mac_loopback = (fq[F_OP_MODE] == 2'b01);
    assign rx_state     = st;

    p_rd_state_r9: assert property (@(posedge clk) disable iff (rst)
        rd_data[9:8] == rx_state);

    p_loop_code_r7: assert property (@(posedge clk) disable iff (rst)
        mac_loopback |-> (rd_data[5:4] == 2'b01));

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        rd_data[15:10] == 6'd0);

    p_mode_guard_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(tx_stopped && rx_idle)) |=> $stable(op_mode));

endmodule

// File: tb/mac_mode_ctl_tb_top.sv
module mac_mode_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        tx_stopped = 1'b0;
    logic        rx_frm_start = 1'b0;
    logic        rx_frm_end = 1'b0;
    logic        rx_buf_empty = 1'b0;
    logic        force_coll, mac_loopback, mcast_all, promisc;
    logic        stop_backoff, pass_bad, rx_start;
    logic [1:0]  op_mode, rx_state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [15:0] model = '0;

    always #5 clk = ~clk;

    mac_mode_ctl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tx_stopped(tx_stopped), .rx_frm_start(rx_frm_start), .rx_frm_end(rx_frm_end),
        .rx_buf_empty(rx_buf_empty), .force_coll(force_coll), .op_mode(op_mode),
        .mac_loopback(mac_loopback), .mcast_all(mcast_all), .promisc(promisc),
        .stop_backoff(stop_backoff), .pass_bad(pass_bad), .rx_start(rx_start),
        .rx_state(rx_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        rx_frm_start = 1'b1;
        @(negedge clk);
        rx_frm_start = 1'b0;
    endtask

    // next stored fields per the guard rules, bit layout from the requirements
    function automatic logic [15:0] apply(input logic [15:0] old, input logic [15:0] d,
                                          input logic txs, input logic rxs);
        logic [15:0] n;
        n = old;
        n[0] = d[0];
        if (rxs) n[3:1] = d[3:1];
        if (txs && rxs) n[5:4] = d[5:4];
        if (txs) n[7:6] = d[7:6];
        n[15:8] = '0;
        return n;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 rx_state", rx_state, 2'b00);
        chk("R1 outputs", {force_coll, op_mode, mac_loopback, mcast_all, promisc,
                           stop_backoff, pass_bad, rx_start}, 9'd0);

        // R3 R4 R5 R6 R8 R9 sweep over guard conditions and patterns
        for (int txs = 0; txs < 2; txs++) begin
            for (int rxrun = 0; rxrun < 2; rxrun++) begin
                for (int pat = 0; pat < 16; pat++) begin
                    logic [15:0] d;
                    logic [15:0] exp;
                    tx_stopped = txs[0];
                    wr((model & 16'hFFFE) | 16'(rxrun));
                    step();
                    step();
                    d = {pat[3:0], pat[3:0] ^ 4'h5, pat[3:0], pat[3:0]};
                    d[0] = rxrun[0];
                    model = apply(model, d, txs[0], !rxrun[0]);
                    wr(d);
                    exp = model;
                    exp[9:8] = rxrun[0] ? 2'b01 : 2'b00;
                    chk("R3 R4 R5 R6 R8 R9 sweep rd_data", rd_data, exp);
                    chk("R7 loopback decode", mac_loopback, model[5:4] == 2'b01);
                    chk("R4 R5 outputs", {force_coll, stop_backoff, op_mode},
                        {model[6], model[7], model[5:4]});
                end
            end
        end

        // back to stopped, both engines idle
        tx_stopped = 1'b1;
        wr(16'h0000);
        step(); step();
        model = 16'h0000;

        // R7 reserved mode codes stored but not loopback
        wr(16'h0020);
        chk("R7 code 10 stored", op_mode, 2'b10);
        chk("R7 code 10 no loopback", mac_loopback, 1'b0);
        wr(16'h0030);
        chk("R7 code 11 no loopback", mac_loopback, 1'b0);
        wr(16'h0010);
        chk("R7 code 01 loopback", mac_loopback, 1'b1);
        // R8 R9 reserved and state bits ignore writes
        wr(16'hFF00);
        chk("R8 R9 reserved/state readback", rd_data, 16'h0000);

        // R10 start: write edge N, running after N+1
        wr(16'h0001);
        chk("R10 not yet running", rx_state, 2'b00);
        step();
        chk("R10 running", rx_state, 2'b01);
        // R2 enable bit writable while running
        chk("R2 enable bit", rx_start, 1'b1);

        // R3 guarded write blocked while running, R6 tx field still allowed
        wr(16'h004F);
        chk("R3 R6 mixed write", rd_data, 16'h0141);

        // R11 idle stop
        wr(16'h0040);
        chk("R11 still running after clear", rx_state, 2'b01);
        step();
        chk("R11 idle stop", rx_state, 2'b00);

        // R11 stop waits for frame end
        wr(16'h0001);
        step();
        pulse_start();
        wr(16'h0000);
        step(); step(); step();
        chk("R11 waits for frame", rx_state, 2'b01);
        @(negedge clk);
        rx_frm_end = 1'b1;
        @(negedge clk);
        rx_frm_end = 1'b0;
        chk("R11 stop at frame end", rx_state, 2'b00);

        // R13 start strobe while stopped is ignored
        pulse_start();
        wr(16'h0001);
        step();
        chk("R13 running", rx_state, 2'b01);
        wr(16'h0000);
        step();
        chk("R13 no stale frame", rx_state, 2'b00);

        // R12 suspend and resume
        wr(16'h0001);
        step();
        @(negedge clk);
        rx_buf_empty = 1'b1;
        step();
        chk("R12 suspended", rx_state, 2'b10);
        chk("R9 suspended code", rd_data[9:8], 2'b10);
        wr(16'h0003);
        chk("R3 blocked while suspended", pass_bad, 1'b0);
        @(negedge clk);
        rx_buf_empty = 1'b0;
        step();
        chk("R12 resumed", rx_state, 2'b01);
        @(negedge clk);
        rx_buf_empty = 1'b1;
        step();
        chk("R12 suspended again", rx_state, 2'b10);
        wr(16'h0000);
        step();
        chk("R12 stop from suspended", rx_state, 2'b00);
        rx_buf_empty = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule